// File: doc/BRIEF.md
# Segmented Bus Line Tester and Repair Manager

This block sits at one end of a bus that is split into segments, with a coupler between neighbouring segments and a loop-back reflector that can be placed at the far side of any segment. On a start request it resets every coupler and then runs a line test. The line test drives a fixed sequence of patterns, one per cycle, toward the reflector. The reflector can be told to return each pattern inverted. After a fixed round trip, the block compares what comes back with what it should see and collects the lines that failed.

A line test shows which wires are broken but not in which segment. So when any line fails, a localisation phase follows. The reflection point moves outward one segment at a time, with only the couplers up to that point enabled, and the whole pattern sequence runs again. A line that first fails at segment k is charged to segment k. The per-segment fault lists are kept for later readout. A segment whose fault count is within the number of spare lines gets a repair configuration. A segment with more faults than spares is flagged as unrepairable and receives no configuration.

Top module: `bus_test_mgr`

## Requirements
- R1: After reset the block is idle: busy and done low, cplRst zero, cplEn all ones, reflSel equal to NUM_SEGS-1, patOut zero, reflInv low, cfgLoad zero, every fault list empty and anyUnrep low.
- R2: A start accepted while idle or done gives exactly one cycle with cplRst all ones and cplEn all zero, and it empties every fault list and the line result before testing begins.
- R3: A test pass drives 4*NUM_LINES patterns on consecutive cycles. For pattern index i, bit i/4 is the walking bit. Bit 1 of i set selects walking-zero (all ones except that bit), and clear selects walking-one. Bit 0 of i set raises reflInv for that pattern, so every inverted pattern directly follows its plain copy.
- R4: Returned data is compared with the expected value (the pattern, inverted when reflInv was high) exactly RT_LAT cycles after the pattern was driven. Any differing bit marks that line as failed, and lineFail shows the failed lines of the full-length test.
- R5: When the full-length test finds no failed line, no localisation pass runs, reflSel never leaves NUM_SEGS-1, no cfgLoad pulse is issued, and done is reached.
- R6: When lines fail, one localisation pass is run for each segment k, in ascending order, with reflSel equal to k and cplEn holding ones in bits 0 to k only.
- R7: The fault list of segment k holds the lines that fail in the pass reflecting at k and did not fail in any earlier localisation pass.
- R8: A segment is unrepairable when its fault count exceeds NUM_SPARES. statUnrep reports this for the selected segment, and anyUnrep is high when any segment is unrepairable.
- R9: In the configuration phase, each segment with a non-empty, repairable fault list gets exactly one single-cycle cfgLoad pulse on its own bit, in ascending segment order, with cfgData carrying that list. Unrepairable and clean segments get none.
- R10: done stays high, with the lists unchanged, until the next start. A start that arrives while busy is ignored.
- R11: statLines and statCount give the fault list and fault count of the segment chosen by statSel, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a test-and-repair run |
| patOut | output | NUM_LINES | Pattern driven onto the bus lines |
| patIn | input | NUM_LINES | Data returned by the reflector |
| reflInv | output | 1 | Ask the reflector to invert the returned data |
| reflSel | output | SEG_W | Segment at whose far end the reflector is placed |
| cplRst | output | NUM_SEGS | Per-segment coupler control reset |
| cplEn | output | NUM_SEGS | Per-segment coupler enable |
| cfgLoad | output | NUM_SEGS | One-cycle strobe loading a segment's repair configuration |
| cfgData | output | NUM_LINES | Lines to be replaced by spares in the strobed segment |
| lineFail | output | NUM_LINES | Failed lines found by the full-length test |
| statSel | input | SEG_W | Segment chosen for status readout |
| statLines | output | NUM_LINES | Fault list of the chosen segment |
| statCount | output | CNT_W | Number of faulty lines in the chosen segment |
| statUnrep | output | 1 | Chosen segment has more faults than spares |
| anyUnrep | output | 1 | Some segment is unrepairable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |

## Verification
The bench checks the exact order of the pattern sequence and where the inverted copies fall. A generator with a swapped variant bit or a missing inversion would reorder these, and the logged sequence would not match. A fault-free bus must end with no failures and no configuration strobes; if the round trip were misaligned by one cycle, every line would fail instead. Faults placed in the middle and last segments, including a bridge between two lines, show whether lines are charged to the first segment where they fail. A design that did not remove earlier failures would charge a fault to every later segment too. The fault count is tested on both sides of the spare limit. Repeated starts during a run and a restart after an unrepairable result check that the lists are kept while busy and cleared on a restart.

// File: rtl/btm_pkg.sv
package btm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSTCPL,
    ST_LINE,
    ST_LOCATE,
    ST_CONFIG,
    ST_DONE
  } btmState_t;

  typedef struct packed {
    logic clearList;
    logic passStart;
    logic captureLine;
    logic recordSeg;
    logic cfgActive;
  } btmCtl_t;

endpackage

// File: rtl/btm_ctrl.sv
module btm_ctrl
  import btm_pkg::*;
#(
  parameter int NUM_SEGS = 4,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                passDone,
  input  logic                passFail,
  output btmCtl_t             ctl,
  output logic [SEG_W-1:0]    segIdx,
  output logic [SEG_W-1:0]    reflSel,
  output logic [NUM_SEGS-1:0] cplRst,
  output logic [NUM_SEGS-1:0] cplEn,
  output logic                busy,
  output logic                done
);

  localparam logic [SEG_W-1:0] LAST_SEG = SEG_W'(NUM_SEGS - 1);

  btmState_t state;
  logic [SEG_W-1:0] seg;
  logic launched;
  logic [NUM_SEGS-1:0] prefix;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      seg      <= '0;
      launched <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start) state <= ST_RSTCPL;
        end
        ST_RSTCPL: begin
          state    <= ST_LINE;
          seg      <= '0;
          launched <= 1'b0;
        end
        ST_LINE: begin
          if (!launched) launched <= 1'b1;
          if (passDone) begin
            launched <= 1'b0;
            seg      <= '0;
            state    <= passFail ? ST_LOCATE : ST_CONFIG;
          end
        end
        ST_LOCATE: begin
          if (!launched) launched <= 1'b1;
          if (passDone) begin
            launched <= 1'b0;
            if (seg == LAST_SEG) begin
              seg   <= '0;
              state <= ST_CONFIG;
            end else begin
              seg <= seg + 1'b1;
            end
          end
        end
        ST_CONFIG: begin
          if (seg == LAST_SEG) begin
            seg   <= '0;
            state <= ST_DONE;
          end else begin
            seg <= seg + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SEGS; s++) prefix[s] = (s <= int'(seg));
  end

  always_comb begin
    ctl             = '0;
    ctl.clearList   = (state == ST_RSTCPL);
    ctl.passStart   = ((state == ST_LINE) || (state == ST_LOCATE)) && !launched;
    ctl.captureLine = (state == ST_LINE) && passDone;
    ctl.recordSeg   = (state == ST_LOCATE) && passDone;
    ctl.cfgActive   = (state == ST_CONFIG);
  end

  always_comb begin
    case (state)
      ST_RSTCPL: cplEn = '0;
      ST_LOCATE: cplEn = prefix;
      default:   cplEn = '1;
    endcase
  end

  assign segIdx  = seg;
  assign reflSel = (state == ST_LOCATE) ? seg : LAST_SEG;
  assign cplRst  = (state == ST_RSTCPL) ? '1 : '0;
  assign busy    = (state != ST_IDLE) && (state != ST_DONE);
  assign done    = (state == ST_DONE);

endmodule

// File: rtl/btm_pass_engine.sv
module btm_pass_engine #(
  parameter int NUM_LINES = 8,
  parameter int RT_LAT    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 passStart,
  input  logic [NUM_LINES-1:0] patIn,
  output logic [NUM_LINES-1:0] patOut,
  output logic                 reflInv,
  output logic                 passDone,
  output logic [NUM_LINES-1:0] passMask
);

  localparam int TOTAL = 4 * NUM_LINES;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  logic [IDX_W-1:0]     idx;
  logic                 issuing;
  logic                 running;
  logic [NUM_LINES-1:0] expPipe [0:RT_LAT];
  logic [RT_LAT:0]      vPipe;

  logic [IDX_W-3:0]     pos;
  logic [NUM_LINES-1:0] walk;
  logic [NUM_LINES-1:0] curPat;
  logic                 curInv;
  logic [NUM_LINES-1:0] curExp;

  always_comb begin
    pos    = idx[IDX_W-1:2];
    walk   = NUM_LINES'(1) << pos;
    curPat = idx[1] ? ~walk : walk;
    curInv = idx[0];
    curExp = curInv ? ~curPat : curPat;
  end

  assign passDone = running && !issuing && (vPipe == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx      <= '0;
      issuing  <= 1'b0;
      running  <= 1'b0;
      patOut   <= '0;
      reflInv  <= 1'b0;
      vPipe    <= '0;
      passMask <= '0;
      for (int i = 0; i <= RT_LAT; i++) expPipe[i] <= '0;
    end else begin
      patOut     <= issuing ? curPat : '0;
      reflInv    <= issuing && curInv;
      expPipe[0] <= curExp;
      vPipe[0]   <= issuing;
      for (int i = 1; i <= RT_LAT; i++) begin
        expPipe[i] <= expPipe[i-1];
        vPipe[i]   <= vPipe[i-1];
      end
      if (vPipe[RT_LAT]) passMask <= passMask | (patIn ^ expPipe[RT_LAT]);
      if (passDone) running <= 1'b0;
      if (passStart) begin
        issuing  <= 1'b1;
        running  <= 1'b1;
        idx      <= '0;
        passMask <= '0;
      end else if (issuing) begin
        idx <= idx + 1'b1;
        if (idx == LAST_IDX) issuing <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/btm_fault_list.sv
module btm_fault_list #(
  parameter int NUM_LINES  = 8,
  parameter int NUM_SEGS   = 4,
  parameter int NUM_SPARES = 1,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearList,
  input  logic                 captureLine,
  input  logic                 recordSeg,
  input  logic                 cfgActive,
  input  logic [SEG_W-1:0]     segIdx,
  input  logic [NUM_LINES-1:0] passMask,
  input  logic [SEG_W-1:0]     statSel,
  output logic [NUM_LINES-1:0] lineFail,
  output logic [NUM_SEGS-1:0]  cfgLoad,
  output logic [NUM_LINES-1:0] cfgData,
  output logic [NUM_LINES-1:0] statLines,
  output logic [CNT_W-1:0]     statCount,
  output logic                 statUnrep,
  output logic                 anyUnrep
);

  logic [NUM_LINES-1:0] segList [NUM_SEGS];
  logic [CNT_W-1:0]     segCount [NUM_SEGS];
  logic [NUM_SEGS-1:0]  segUnrep;
  logic [NUM_LINES-1:0] cumMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cumMask  <= '0;
      lineFail <= '0;
    end else if (clearList) begin
      cumMask  <= '0;
      lineFail <= '0;
    end else begin
      if (captureLine) lineFail <= passMask;
      if (recordSeg) cumMask <= cumMask | passMask;
    end
  end

  for (genvar s = 0; s < NUM_SEGS; s++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        segList[s] <= '0;
      end else if (clearList) begin
        segList[s] <= '0;
      end else if (recordSeg && (int'(segIdx) == s)) begin
        segList[s] <= passMask & ~cumMask;
      end
    end

    always_comb begin
      segCount[s] = '0;
      for (int b = 0; b < NUM_LINES; b++) segCount[s] = segCount[s] + CNT_W'(segList[s][b]);
    end

    assign segUnrep[s] = (int'(segCount[s]) > NUM_SPARES);
    assign cfgLoad[s]  = cfgActive && (int'(segIdx) == s) &&
                         (segList[s] != '0) && !segUnrep[s];
  end

  assign cfgData   = (cfgLoad != '0) ? segList[segIdx] : '0;
  assign statLines = segList[statSel];
  assign statCount = segCount[statSel];
  assign statUnrep = segUnrep[statSel];
  assign anyUnrep  = |segUnrep;

endmodule

// File: rtl/btm_datapath.sv
module btm_datapath
  import btm_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int NUM_SEGS   = 4,
  parameter int NUM_SPARES = 1,
  parameter int RT_LAT     = 2,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  btmCtl_t              ctl,
  input  logic [SEG_W-1:0]     segIdx,
  input  logic [NUM_LINES-1:0] patIn,
  input  logic [SEG_W-1:0]     statSel,
  output logic [NUM_LINES-1:0] patOut,
  output logic                 reflInv,
  output logic                 passDone,
  output logic                 passFail,
  output logic [NUM_LINES-1:0] lineFail,
  output logic [NUM_SEGS-1:0]  cfgLoad,
  output logic [NUM_LINES-1:0] cfgData,
  output logic [NUM_LINES-1:0] statLines,
  output logic [CNT_W-1:0]     statCount,
  output logic                 statUnrep,
  output logic                 anyUnrep
);

  logic [NUM_LINES-1:0] passMask;

  btm_pass_engine #(
    .NUM_LINES(NUM_LINES),
    .RT_LAT   (RT_LAT)
  ) u_pass (
    .clk      (clk),
    .rstN     (rstN),
    .passStart(ctl.passStart),
    .patIn    (patIn),
    .patOut   (patOut),
    .reflInv  (reflInv),
    .passDone (passDone),
    .passMask (passMask)
  );

  assign passFail = (passMask != '0);

  btm_fault_list #(
    .NUM_LINES (NUM_LINES),
    .NUM_SEGS  (NUM_SEGS),
    .NUM_SPARES(NUM_SPARES)
  ) u_list (
    .clk        (clk),
    .rstN       (rstN),
    .clearList  (ctl.clearList),
    .captureLine(ctl.captureLine),
    .recordSeg  (ctl.recordSeg),
    .cfgActive  (ctl.cfgActive),
    .segIdx     (segIdx),
    .passMask   (passMask),
    .statSel    (statSel),
    .lineFail   (lineFail),
    .cfgLoad    (cfgLoad),
    .cfgData    (cfgData),
    .statLines  (statLines),
    .statCount  (statCount),
    .statUnrep  (statUnrep),
    .anyUnrep   (anyUnrep)
  );

endmodule

// File: rtl/bus_test_mgr.sv
module bus_test_mgr
  import btm_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int NUM_SEGS   = 4,
  parameter int NUM_SPARES = 1,
  parameter int RT_LAT     = 2,
  localparam int SEG_W = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1,
  localparam int CNT_W = $clog2(NUM_LINES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  output logic [NUM_LINES-1:0] patOut,
  input  logic [NUM_LINES-1:0] patIn,
  output logic                 reflInv,
  output logic [SEG_W-1:0]     reflSel,
  output logic [NUM_SEGS-1:0]  cplRst,
  output logic [NUM_SEGS-1:0]  cplEn,
  output logic [NUM_SEGS-1:0]  cfgLoad,
  output logic [NUM_LINES-1:0] cfgData,
  output logic [NUM_LINES-1:0] lineFail,
  input  logic [SEG_W-1:0]     statSel,
  output logic [NUM_LINES-1:0] statLines,
  output logic [CNT_W-1:0]     statCount,
  output logic                 statUnrep,
  output logic                 anyUnrep,
  output logic                 busy,
  output logic                 done
);

  btmCtl_t          ctl;
  logic [SEG_W-1:0] segIdx;
  logic             passDone;
  logic             passFail;

  btm_ctrl #(
    .NUM_SEGS(NUM_SEGS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .passDone(passDone),
    .passFail(passFail),
    .ctl     (ctl),
    .segIdx  (segIdx),
    .reflSel (reflSel),
    .cplRst  (cplRst),
    .cplEn   (cplEn),
    .busy    (busy),
    .done    (done)
  );

  btm_datapath #(
    .NUM_LINES (NUM_LINES),
    .NUM_SEGS  (NUM_SEGS),
    .NUM_SPARES(NUM_SPARES),
    .RT_LAT    (RT_LAT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .segIdx   (segIdx),
    .patIn    (patIn),
    .statSel  (statSel),
    .patOut   (patOut),
    .reflInv  (reflInv),
    .passDone (passDone),
    .passFail (passFail),
    .lineFail (lineFail),
    .cfgLoad  (cfgLoad),
    .cfgData  (cfgData),
    .statLines(statLines),
    .statCount(statCount),
    .statUnrep(statUnrep),
    .anyUnrep (anyUnrep)
  );

endmodule

// File: rtl/bus_test_mgr_chk.sv
module bus_test_mgr_chk #(
  parameter int NUM_LINES  = 8,
  parameter int NUM_SEGS   = 4,
  parameter int NUM_SPARES = 1,
  parameter int SEG_W      = 2,
  parameter int CNT_W      = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 start,
  input logic                 reflInv,
  input logic [SEG_W-1:0]     reflSel,
  input logic [NUM_SEGS-1:0]  cplRst,
  input logic [NUM_SEGS-1:0]  cplEn,
  input logic [NUM_SEGS-1:0]  cfgLoad,
  input logic [NUM_LINES-1:0] cfgData,
  input logic [NUM_LINES-1:0] statLines,
  input logic [CNT_W-1:0]     statCount,
  input logic                 statUnrep,
  input logic                 busy,
  input logic                 done
);

  logic [NUM_SEGS-1:0] expPrefix;
  always_comb begin
    for (int s = 0; s < NUM_SEGS; s++) expPrefix[s] = (s <= int'(reflSel));
  end

  assert_rst_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cplRst != '0) |-> (cplRst == '1) && (cplEn == '0));

  assert_rst_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cplRst != '0) |=> (cplRst == '0));

  assert_inv_alternates_R3: assert property (@(posedge clk) disable iff (!rstN)
    reflInv |=> !reflInv);

  assert_locate_prefix_R6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(reflSel) != NUM_SEGS - 1) |-> (cplEn == expPrefix));

  assert_unrep_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    statUnrep == ($countones(statLines) > NUM_SPARES));

  assert_cfg_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cfgLoad));

  assert_cfg_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad != '0) |-> ($countones(cfgData) >= 1) && ($countones(cfgData) <= NUM_SPARES));

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_count_R11: assert property (@(posedge clk) disable iff (!rstN)
    int'(statCount) == $countones(statLines));

endmodule

bind bus_test_mgr bus_test_mgr_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_SEGS  (NUM_SEGS),
  .NUM_SPARES(NUM_SPARES),
  .SEG_W     (SEG_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .reflInv  (reflInv),
  .reflSel  (reflSel),
  .cplRst   (cplRst),
  .cplEn    (cplEn),
  .cfgLoad  (cfgLoad),
  .cfgData  (cfgData),
  .statLines(statLines),
  .statCount(statCount),
  .statUnrep(statUnrep),
  .busy     (busy),
  .done     (done)
);

// File: tb/bus_test_mgr_bench.sv
module bus_test_mgr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int S  = 4;
  localparam int SP = 1;
  localparam int SW = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  patOut, patIn, cfgData, lineFail, statLines;
  logic          reflInv, statUnrep, anyUnrep, busy, done;
  logic [SW-1:0] reflSel, statSel = '0;
  logic [S-1:0]  cplRst, cplEn, cfgLoad;
  logic [CW-1:0] statCount;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_test_mgr u_bus_test_mgr (
    .clk(clk), .rstN(rstN), .start(start), .patOut(patOut), .patIn(patIn),
    .reflInv(reflInv), .reflSel(reflSel), .cplRst(cplRst), .cplEn(cplEn),
    .cfgLoad(cfgLoad), .cfgData(cfgData), .lineFail(lineFail), .statSel(statSel),
    .statLines(statLines), .statCount(statCount), .statUnrep(statUnrep),
    .anyUnrep(anyUnrep), .busy(busy), .done(done)
  );

  // Fault model of the bus, applied on the way out to the reflector
  logic [N-1:0] sa0 [S];
  logic [N-1:0] sa1 [S];
  logic         brEn [S];
  int           brA [S];
  int           brB [S];

  function automatic logic [N-1:0] travel(input logic [N-1:0] d, input logic inv,
                                          input int sel, input logic [S-1:0] en);
    logic [N-1:0] v;
    logic t;
    v = d;
    for (int s = 0; s < S; s++) begin
      if (s <= sel) begin
        if (!en[s]) v = '0;
        else begin
          v = (v | sa1[s]) & ~sa0[s];
          if (brEn[s]) begin
            t = v[brA[s]] & v[brB[s]];
            v[brA[s]] = t;
            v[brB[s]] = t;
          end
        end
      end
    end
    return inv ? ~v : v;
  endfunction

  logic [N-1:0] r1, r2;
  always_ff @(posedge clk) begin
    r1 <= travel(patOut, reflInv, int'(reflSel), cplEn);
    r2 <= r1;
  end
  assign patIn = r2;

  // Monitors
  logic [N-1:0] patLog [0:31];
  logic         invLog [0:31];
  int           patCount, rstPulses, cfgCount, selCount, prefixBad, minSel;
  int           selLog [0:7];
  logic [N-1:0] cfgSeen [S];
  int           cfgLoadsPerSeg [S];
  int           cfgOrder [0:7];
  int           prevSel;

  always @(negedge clk) begin
    if (rstN) begin
      if (patOut != '0) begin
        if (patCount < 32) begin
          patLog[patCount] = patOut;
          invLog[patCount] = reflInv;
        end
        patCount++;
      end
      if (cplRst != '0) begin
        rstPulses++;
        if (cplRst != '1 || cplEn != '0) prefixBad++;
      end
      if (int'(reflSel) != prevSel) begin
        if (selCount < 8) selLog[selCount] = int'(reflSel);
        selCount++;
        prevSel = int'(reflSel);
      end
      if (int'(reflSel) < minSel) minSel = int'(reflSel);
      if (int'(reflSel) != S-1) begin
        for (int s = 0; s < S; s++)
          if (cplEn[s] != (s <= int'(reflSel))) prefixBad++;
      end
      for (int s = 0; s < S; s++) begin
        if (cfgLoad[s]) begin
          cfgSeen[s] = cfgData;
          cfgLoadsPerSeg[s]++;
          if (cfgCount < 8) cfgOrder[cfgCount] = s;
          cfgCount++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clearFaults();
    for (int s = 0; s < S; s++) begin
      sa0[s] = '0; sa1[s] = '0; brEn[s] = 1'b0; brA[s] = 0; brB[s] = 0;
    end
  endtask

  task automatic clearLogs();
    patCount = 0; rstPulses = 0; cfgCount = 0; selCount = 0; prefixBad = 0;
    minSel = S-1; prevSel = S-1;
    for (int s = 0; s < S; s++) begin cfgSeen[s] = '0; cfgLoadsPerSeg[s] = 0; end
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic runToDone();
    int waitCyc;
    clearLogs();
    pulseStart();
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk(done == 1'b1, "R10 run reaches done", 32'(done), 32'd1);
  endtask

  task automatic checkSeg(input int s, input logic [N-1:0] expLines, input bit expUnrep, input string req);
    int cnt;
    statSel = SW'(s);
    #1;
    cnt = $countones(expLines);
    chk(statLines == expLines, req, 32'(statLines), 32'(expLines));
    chk(int'(statCount) == cnt, "R11 count readout", 32'(statCount), 32'(cnt));
    chk(statUnrep == expUnrep, "R8 unrepairable flag", 32'(statUnrep), 32'(expUnrep));
  endtask

  task automatic testReset();
    chk(!busy && !done, "R1 idle after reset", {30'd0, busy, done}, 32'd0);
    chk(cplRst == '0, "R1 cplRst", 32'(cplRst), 32'd0);
    chk(cplEn == '1, "R1 cplEn", 32'(cplEn), 32'hF);
    chk(int'(reflSel) == S-1, "R1 reflSel", 32'(reflSel), 32'(S-1));
    chk(patOut == '0 && !reflInv, "R1 pattern idle", 32'(patOut), 32'd0);
    chk(cfgLoad == '0 && !anyUnrep, "R1 cfg and flag", 32'(cfgLoad), 32'd0);
    for (int s = 0; s < S; s++) checkSeg(s, '0, 1'b0, "R1 empty list");
  endtask

  task automatic testCleanBus();
    logic [N-1:0] walk, pat;
    int bad;
    clearFaults();
    runToDone();
    chk(rstPulses == 1 && prefixBad == 0, "R2 single coupler reset pulse", 32'(rstPulses), 32'd1);
    chk(patCount == 4*N, "R3 pattern count", 32'(patCount), 32'(4*N));
    bad = 0;
    for (int i = 0; i < 4*N; i++) begin
      walk = N'(1) << (i / 4);
      pat  = ((i & 2) != 0) ? ~walk : walk;
      if (patLog[i] != pat || invLog[i] != ((i & 1) != 0)) begin
        bad++;
        $display("FAIL R3 pattern %0d actual=0x%0h/%0b expected=0x%0h/%0b",
                 i, patLog[i], invLog[i], pat, (i & 1) != 0);
      end
    end
    chk(bad == 0, "R3 pattern order", 32'(bad), 32'd0);
    chk(lineFail == '0, "R4 clean bus no failures", 32'(lineFail), 32'd0);
    chk(minSel == S-1, "R5 no localisation", 32'(minSel), 32'(S-1));
    chk(cfgCount == 0, "R5 no configuration", 32'(cfgCount), 32'd0);
  endtask

  task automatic testSingleFault();
    clearFaults();
    sa0[1] = 8'h08;
    runToDone();
    chk(lineFail == 8'h08, "R4 failed line found", 32'(lineFail), 32'h08);
    chk(selCount == 4, "R6 localisation step count", 32'(selCount), 32'd4);
    for (int k = 0; k < 4; k++)
      chk(selLog[k] == k, "R6 localisation order", 32'(selLog[k]), 32'(k));
    chk(prefixBad == 0, "R6 coupler prefix", 32'(prefixBad), 32'd0);
    checkSeg(0, '0, 1'b0, "R7 seg0 clean");
    checkSeg(1, 8'h08, 1'b0, "R7 seg1 list");
    checkSeg(2, '0, 1'b0, "R7 seg2 not charged again");
    checkSeg(3, '0, 1'b0, "R7 seg3 not charged again");
    chk(cfgCount == 1 && cfgLoadsPerSeg[1] == 1, "R9 one load", 32'(cfgCount), 32'd1);
    chk(cfgSeen[1] == 8'h08, "R9 cfg data", 32'(cfgSeen[1]), 32'h08);
    chk(!anyUnrep, "R8 no unrepairable", 32'(anyUnrep), 32'd0);
  endtask

  task automatic testUnrepairable();
    clearFaults();
    sa0[0] = 8'h80;
    sa1[2] = 8'h21;
    brEn[3] = 1'b1; brA[3] = 1; brB[3] = 2;
    runToDone();
    chk(lineFail == 8'hA7, "R4 all failed lines", 32'(lineFail), 32'hA7);
    checkSeg(0, 8'h80, 1'b0, "R7 seg0 list");
    checkSeg(1, '0, 1'b0, "R7 seg1 clean");
    checkSeg(2, 8'h21, 1'b1, "R7 seg2 list over limit");
    checkSeg(3, 8'h06, 1'b1, "R7 seg3 bridge list");
    chk(anyUnrep, "R8 anyUnrep", 32'(anyUnrep), 32'd1);
    chk(cfgCount == 1 && cfgLoadsPerSeg[0] == 1, "R9 only repairable loaded", 32'(cfgCount), 32'd1);
    chk(cfgSeen[0] == 8'h80, "R9 seg0 data", 32'(cfgSeen[0]), 32'h80);
  endtask

  task automatic testCfgOrder();
    clearFaults();
    sa0[0] = 8'h01;
    sa1[3] = 8'h40;
    runToDone();
    chk(cfgCount == 2, "R9 two loads", 32'(cfgCount), 32'd2);
    chk(cfgOrder[0] == 0 && cfgOrder[1] == 3, "R9 ascending order",
        32'((cfgOrder[0] << 4) | cfgOrder[1]), 32'h03);
    chk(cfgSeen[3] == 8'h40, "R9 seg3 data", 32'(cfgSeen[3]), 32'h40);
  endtask

  task automatic testStartIgnoredAndHold();
    int waitCyc;
    clearFaults();
    sa0[1] = 8'h10;
    clearLogs();
    pulseStart();
    repeat (10) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCyc = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk(rstPulses == 1, "R10 start while busy ignored", 32'(rstPulses), 32'd1);
    checkSeg(1, 8'h10, 1'b0, "R10 list intact");
    repeat (20) @(negedge clk);
    chk(done && !busy, "R10 done held", {30'd0, busy, done}, 32'd1);
    checkSeg(1, 8'h10, 1'b0, "R10 list held");
  endtask

  task automatic testRestartClears();
    clearFaults();
    sa1[2] = 8'h03;
    runToDone();
    chk(anyUnrep, "R8 unrepairable before restart", 32'(anyUnrep), 32'd1);
    clearFaults();
    runToDone();
    chk(rstPulses == 1, "R2 restart from done", 32'(rstPulses), 32'd1);
    chk(!anyUnrep && lineFail == '0, "R2 results cleared", 32'(lineFail), 32'd0);
    checkSeg(2, '0, 1'b0, "R2 list cleared");
  endtask

  initial begin
    clearFaults();
    clearLogs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCleanBus();
    testSingleFault();
    testUnrepairable();
    testCfgOrder();
    testStartIgnoredAndHold();
    testRestartClears();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule